// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the eight event flags raised by two timer/counters and presents them to the bus and to the interrupt logic. Each flag is raised by a single-cycle event pulse from the counter logic and stays high until software clears it or the interrupt controller acknowledges it. The overflow and capture flags rise on the clock after their event. The four compare flags rise one enabled timer tick later than the match itself.

The capture flag has two sources. One is the capture pin event. The other is the TOP-reached pulse, which is used when a mode input reports that the capture register is serving as the counter's TOP value. Forced-compare strobes enter the block but never raise a flag. The block passes on raw flag levels, and masking against interrupt enables happens outside it.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, or whenever `rst_n` is low, every bit of `rd_data` and `irq_flags` is zero.
- R2: The overflow flags sit at bit 7 (timer 1) and bit 1 (timer 0). Each is set on the clock edge that samples its overflow pulse.
- R3: Bit 4 is reserved and always reads zero, whatever is written to it or acknowledged on it.
- R4: A bus write clears every flag whose `wr_data` bit is one and leaves every flag whose bit is zero unchanged.
- R5: A one on `ack[i]` clears flag i on that clock edge.
- R6: The compare flags sit at bit 6 (timer 1 A), bit 5 (timer 1 B), bit 0 (timer 0 A) and bit 2 (timer 0 B). A match seen on an enabled timer tick sets the flag on the next enabled tick of the same timer, and not on the tick of the match.
- R7: A compare match pulse presented while its timer tick enable is low is ignored. A match that has been captured waits through any disabled cycles until the next enabled tick.
- R8: Forced-compare strobes never set any flag.
- R9: When `cap_is_top` is 0, bit 3 is set by the capture pin event, and the TOP-reached pulse has no effect.
- R10: When `cap_is_top` is 1, bit 3 is set by the TOP-reached pulse, and the capture pin event has no effect.
- R11: If a set and a clear (write-one or acknowledge) reach the same flag on the same edge, the flag ends up set.
- R12: `irq_flags` always equals `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_tick | input | 1 | Timer 1 count enable (timer clock tick) |
| t0_tick | input | 1 | Timer 0 count enable (timer clock tick) |
| t1_ovf | input | 1 | Timer 1 qualified overflow pulse |
| t1_cmpa | input | 1 | Timer 1 compare A equality |
| t1_cmpb | input | 1 | Timer 1 compare B equality |
| t1_force_a | input | 1 | Timer 1 forced compare A strobe |
| t1_force_b | input | 1 | Timer 1 forced compare B strobe |
| t1_cap | input | 1 | Capture pin event |
| t1_top | input | 1 | Timer 1 reached TOP |
| cap_is_top | input | 1 | Capture register serves as TOP |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t0_cmpa | input | 1 | Timer 0 compare A equality |
| t0_cmpb | input | 1 | Timer 0 compare B equality |
| t0_force_a | input | 1 | Timer 0 forced compare A strobe |
| t0_force_b | input | 1 | Timer 0 forced compare B strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data (one clears) |
| ack | input | 8 | Per-flag vector acknowledge pulses |
| rd_data | output | 8 | Register value for bus reads |
| irq_flags | output | 8 | Raw flag levels for interrupt requests |

## Verification
The bench drives each event source alone so that a wrong bit position shows up. It follows with writes of all ones, of zero, and of single bits, which separate selective clearing from blanket clearing. The compare paths are driven with the tick enable held high and with gaps in it, which separates "one enabled tick later" from "one clock later" and from "same tick". Capture and TOP pulses are each applied under both mode settings, and events are made to coincide with write-one and acknowledge to show that the set takes priority.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
  localparam int FLAG_W = 8;

  localparam int B_T1_OVF  = 7;
  localparam int B_T1_CMPA = 6;
  localparam int B_T1_CMPB = 5;
  localparam int B_RSVD    = 4;
  localparam int B_T1_CAP  = 3;
  localparam int B_T0_CMPB = 2;
  localparam int B_T0_OVF  = 1;
  localparam int B_T0_CMPA = 0;

  localparam logic [FLAG_W-1:0] IMPL_MASK  = ~(FLAG_W'(1) << B_RSVD);
  localparam logic [FLAG_W-1:0] DELAY_MASK = (FLAG_W'(1) << B_T1_CMPA) | (FLAG_W'(1) << B_T1_CMPB)
                                           | (FLAG_W'(1) << B_T0_CMPA) | (FLAG_W'(1) << B_T0_CMPB);
  localparam logic [FLAG_W-1:0] T1_MASK    = (FLAG_W'(1) << B_T1_OVF) | (FLAG_W'(1) << B_T1_CMPA)
                                           | (FLAG_W'(1) << B_T1_CMPB) | (FLAG_W'(1) << B_T1_CAP);
endpackage

// File: rtl/tifr_src_map.sv
module tifr_src_map
  import tifr_pkg::*;
(
  input  logic              t1_ovf,
  input  logic              t1_cmpa,
  input  logic              t1_cmpb,
  input  logic              t1_cap,
  input  logic              t1_top,
  input  logic              cap_is_top,
  input  logic              t0_ovf,
  input  logic              t0_cmpa,
  input  logic              t0_cmpb,
  output logic [FLAG_W-1:0] evt
);
  always_comb begin
    evt            = '0;
    evt[B_T1_OVF]  = t1_ovf;
    evt[B_T1_CMPA] = t1_cmpa;
    evt[B_T1_CMPB] = t1_cmpb;
    evt[B_T1_CAP]  = cap_is_top ? t1_top : t1_cap;
    evt[B_T0_CMPB] = t0_cmpb;
    evt[B_T0_OVF]  = t0_ovf;
    evt[B_T0_CMPA] = t0_cmpa;
  end
endmodule

// File: rtl/irq_flag_evt.sv
module irq_flag_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = evt | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_flag_cmp.sv
module irq_flag_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic match,
  input  logic clr,
  output logic flag,
  output logic pend
);
  logic pend_q, pend_d;
  logic flag_q, flag_d;
  logic set_now;

  always_comb begin
    pend_d  = tick_en ? match : pend_q;
    set_now = tick_en & pend_q;
    flag_d  = set_now | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign pend = pend_q;
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tifr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t1_tick,
  input  logic              t0_tick,
  input  logic              t1_ovf,
  input  logic              t1_cmpa,
  input  logic              t1_cmpb,
  input  logic              t1_force_a,
  input  logic              t1_force_b,
  input  logic              t1_cap,
  input  logic              t1_top,
  input  logic              cap_is_top,
  input  logic              t0_ovf,
  input  logic              t0_cmpa,
  input  logic              t0_cmpb,
  input  logic              t0_force_a,
  input  logic              t0_force_b,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] ack,
  output logic [FLAG_W-1:0] rd_data,
  output logic [FLAG_W-1:0] irq_flags
);
  logic [FLAG_W-1:0] evt;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] cmp_pend;

  // Forced-compare strobes act only on output pins elsewhere; they are
  // deliberately kept out of the flag sources (observed by the checker).
  tifr_src_map i_src (
    .t1_ovf     (t1_ovf),
    .t1_cmpa    (t1_cmpa),
    .t1_cmpb    (t1_cmpb),
    .t1_cap     (t1_cap),
    .t1_top     (t1_top),
    .cap_is_top (cap_is_top),
    .t0_ovf     (t0_ovf),
    .t0_cmpa    (t0_cmpa),
    .t0_cmpb    (t0_cmpb),
    .evt        (evt)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (!IMPL_MASK[i]) begin : g_rsvd
      // Router ties the reserved source low; no storage is built.
      assign flag_q[i]   = evt[i];
      assign cmp_pend[i] = 1'b0;
    end else begin : g_impl
      logic clr_i;
      assign clr_i = (wr_en & wr_data[i]) | ack[i];
      if (DELAY_MASK[i]) begin : g_cmp
        logic tick_i;
        assign tick_i = T1_MASK[i] ? t1_tick : t0_tick;
        irq_flag_cmp i_cell (
          .clk     (clk),
          .rst_n   (rst_n),
          .tick_en (tick_i),
          .match   (evt[i]),
          .clr     (clr_i),
          .flag    (flag_q[i]),
          .pend    (cmp_pend[i])
        );
      end else begin : g_evt
        assign cmp_pend[i] = 1'b0;
        irq_flag_evt i_cell (
          .clk   (clk),
          .rst_n (rst_n),
          .evt   (evt[i]),
          .clr   (clr_i),
          .flag  (flag_q[i])
        );
      end
    end
  end

  assign rd_data   = flag_q;
  assign irq_flags = flag_q;
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       t1_tick,
  input logic       t0_tick,
  input logic       t1_ovf,
  input logic       t1_cmpa,
  input logic       t1_cmpb,
  input logic       t1_force_a,
  input logic       t1_force_b,
  input logic       t1_cap,
  input logic       t1_top,
  input logic       cap_is_top,
  input logic       t0_ovf,
  input logic       t0_cmpa,
  input logic       t0_cmpb,
  input logic       t0_force_a,
  input logic       t0_force_b,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ack,
  input logic [7:0] rd_data,
  input logic [7:0] irq_flags,
  input logic [7:0] cmp_pend
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] == 1'b0);
  p_rsvd_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en && wr_data[4]) || ack[4]) |=> !rd_data[4]);
  p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && wr_en && wr_data[7] && !t1_ovf) |=> !rd_data[7]);
  p_wr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && wr_en && !wr_data[1] && !ack[1]) |=> rd_data[1]);
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && ack[1] && !t0_ovf) |=> !rd_data[1]);
  p_cmp_after_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> $past(cmp_pend[0]));
  p_cmp_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[6]) |-> $past(t1_tick));
  p_force_t1a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_tick && t1_force_a && !t1_cmpa) |=> !cmp_pend[6]);
  p_force_t1b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_tick && t1_force_b && !t1_cmpb) |=> !cmp_pend[5]);
  p_force_t0a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_tick && t0_force_a && !t0_cmpa) |=> !cmp_pend[0]);
  p_force_t0b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_tick && t0_force_b && !t0_cmpb) |=> !cmp_pend[2]);
  p_cap_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_is_top && t1_cap) |=> rd_data[3]);
  p_cap_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_is_top && t1_top) |=> rd_data[3]);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    t0_ovf |=> rd_data[1]);
  p_levels_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags == rd_data);
endmodule

bind tmr_irq_flags tmr_irq_flags_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .t1_tick    (t1_tick),
  .t0_tick    (t0_tick),
  .t1_ovf     (t1_ovf),
  .t1_cmpa    (t1_cmpa),
  .t1_cmpb    (t1_cmpb),
  .t1_force_a (t1_force_a),
  .t1_force_b (t1_force_b),
  .t1_cap     (t1_cap),
  .t1_top     (t1_top),
  .cap_is_top (cap_is_top),
  .t0_ovf     (t0_ovf),
  .t0_cmpa    (t0_cmpa),
  .t0_cmpb    (t0_cmpb),
  .t0_force_a (t0_force_a),
  .t0_force_b (t0_force_b),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .ack        (ack),
  .rd_data    (rd_data),
  .irq_flags  (irq_flags),
  .cmp_pend   (cmp_pend)
);

// File: tb/test_tmr_irq_flags.sv
`timescale 1ns/1ps
module test_tmr_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       t1_tick, t0_tick;
  logic       t1_ovf, t1_cmpa, t1_cmpb, t1_force_a, t1_force_b;
  logic       t1_cap, t1_top, cap_is_top;
  logic       t0_ovf, t0_cmpa, t0_cmpb, t0_force_a, t0_force_b;
  logic       wr_en;
  logic [7:0] wr_data, ack;
  logic [7:0] rd_data, irq_flags;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .t1_tick(t1_tick), .t0_tick(t0_tick),
    .t1_ovf(t1_ovf), .t1_cmpa(t1_cmpa), .t1_cmpb(t1_cmpb),
    .t1_force_a(t1_force_a), .t1_force_b(t1_force_b),
    .t1_cap(t1_cap), .t1_top(t1_top), .cap_is_top(cap_is_top),
    .t0_ovf(t0_ovf), .t0_cmpa(t0_cmpa), .t0_cmpb(t0_cmpb),
    .t0_force_a(t0_force_a), .t0_force_b(t0_force_b),
    .wr_en(wr_en), .wr_data(wr_data), .ack(ack),
    .rd_data(rd_data), .irq_flags(irq_flags)
  );

  // Row: req[41:38] stim[37:25] wr_en[24] wr_data[23:16] ack[15:8] expected[7:0]
  // stim = {t1_ovf,t1_cmpa,t1_cmpb,t1_force_a,t1_force_b,t1_cap,t1_top,cap_is_top,
  //         t0_ovf,t0_cmpa,t0_cmpb,t0_force_a,t0_force_b}
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {4'd2,  13'b10000000_00000, 1'b0, 8'h00, 8'h00, 8'h80}, // R2 timer1 overflow
    {4'd2,  13'b00000000_10000, 1'b0, 8'h00, 8'h00, 8'h82}, // R2 timer0 overflow
    {4'd4,  13'b00000000_00000, 1'b1, 8'h80, 8'h00, 8'h02}, // R4 write-one clears
    {4'd4,  13'b00000000_00000, 1'b1, 8'h00, 8'h00, 8'h02}, // R4 write zero no effect
    {4'd5,  13'b00000000_00000, 1'b0, 8'h00, 8'h02, 8'h00}, // R5 acknowledge
    {4'd6,  13'b01000000_00000, 1'b0, 8'h00, 8'h00, 8'h00}, // R6 not on match tick
    {4'd6,  13'b00000000_00000, 1'b0, 8'h00, 8'h00, 8'h40}, // R6 next tick
    {4'd6,  13'b00000000_01100, 1'b0, 8'h00, 8'h00, 8'h40}, // R6 timer0 A+B
    {4'd6,  13'b00000000_00000, 1'b0, 8'h00, 8'h00, 8'h45}, // R6
    {4'd8,  13'b00011000_00011, 1'b0, 8'h00, 8'h00, 8'h45}, // R8 forced strobes
    {4'd8,  13'b00000000_00000, 1'b0, 8'h00, 8'h00, 8'h45}, // R8 still nothing new
    {4'd3,  13'b00000000_00000, 1'b1, 8'hFF, 8'h00, 8'h00}, // R3 write all ones
    {4'd9,  13'b00000100_00000, 1'b0, 8'h00, 8'h00, 8'h08}, // R9 capture pin
    {4'd5,  13'b00000000_00000, 1'b0, 8'h00, 8'h08, 8'h00}, // R5
    {4'd10, 13'b00000101_00000, 1'b0, 8'h00, 8'h00, 8'h00}, // R10 pin ignored
    {4'd10, 13'b00000011_00000, 1'b0, 8'h00, 8'h00, 8'h08}, // R10 TOP sets
    {4'd9,  13'b00000010_00000, 1'b1, 8'h08, 8'h00, 8'h00}, // R9 TOP ignored
    {4'd11, 13'b10000000_00000, 1'b1, 8'h80, 8'h00, 8'h80}, // R11 set beats write
    {4'd11, 13'b10000000_00000, 1'b0, 8'h00, 8'h80, 8'h80}, // R11 set beats ack
    {4'd5,  13'b00000000_00000, 1'b0, 8'h00, 8'h80, 8'h00}, // R5
    {4'd6,  13'b00100000_00000, 1'b0, 8'h00, 8'h00, 8'h00}, // R6 timer1 B
    {4'd11, 13'b00000000_00000, 1'b1, 8'h20, 8'h00, 8'h20}, // R11 delayed set beats write
    {4'd5,  13'b00000000_00000, 1'b0, 8'h00, 8'h20, 8'h00}, // R5
    {4'd3,  13'b00000000_00000, 1'b1, 8'h10, 8'h10, 8'h00}  // R3 reserved bit
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    {t1_ovf, t1_cmpa, t1_cmpb, t1_force_a, t1_force_b, t1_cap, t1_top, cap_is_top} = '0;
    {t0_ovf, t0_cmpa, t0_cmpb, t0_force_a, t0_force_b} = '0;
    wr_en = 1'b0; wr_data = '0; ack = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    t1_tick = 1'b1; t0_tick = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(rd_data, 8'h00, "R1 reset rd_data");
    check(irq_flags, 8'h00, "R1 reset irq_flags");
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {t1_ovf, t1_cmpa, t1_cmpb, t1_force_a, t1_force_b, t1_cap, t1_top, cap_is_top,
       t0_ovf, t0_cmpa, t0_cmpb, t0_force_a, t0_force_b} = VEC[k][37:25];
      wr_en = VEC[k][24]; wr_data = VEC[k][23:16]; ack = VEC[k][15:8];
      step();
      check(rd_data, VEC[k][7:0], $sformatf("R%0d row %0d", VEC[k][41:38], k));
      check(irq_flags, rd_data, "R12 levels");
    end

    // R7: match with tick low is not captured
    @(negedge clk); idle_inputs(); t1_tick = 1'b0; t1_cmpa = 1'b1;
    step();
    @(negedge clk); t1_cmpa = 1'b0; t1_tick = 1'b1;
    step(); check(rd_data, 8'h00, "R7 disabled match ignored a");
    step(); check(rd_data, 8'h00, "R7 disabled match ignored b");

    // R7: captured match waits for the next enabled tick
    @(negedge clk); t1_cmpa = 1'b1;
    step();
    @(negedge clk); t1_cmpa = 1'b0; t1_tick = 1'b0;
    step(); step(); step();
    check(rd_data, 8'h00, "R7 waits through disabled ticks");
    @(negedge clk); t1_tick = 1'b1;
    step();
    check(rd_data, 8'h40, "R7 set on next enabled tick");

    // R7: timer0 tick does not advance a timer1 compare
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hFF; step();
    @(negedge clk); idle_inputs(); t1_cmpb = 1'b1; step();
    @(negedge clk); t1_cmpb = 1'b0; t1_tick = 1'b0; t0_tick = 1'b1; step();
    check(rd_data, 8'h00, "R7 other timer tick ignored");
    @(negedge clk); t1_tick = 1'b1; step();
    check(rd_data, 8'h20, "R6 timer1 B on own tick");

    // R1: asynchronous reset clears live flags
    @(negedge clk); t0_ovf = 1'b1; step();
    @(negedge clk); t0_ovf = 1'b0;
    check(rd_data, 8'h22, "R2 before reset");
    #2 rst_n = 1'b0; #1;
    check(rd_data, 8'h00, "R1 async reset");
    @(negedge clk); rst_n = 1'b1;
    step();
    check(rd_data, 8'h00, "R1 after reset release");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule